// File: doc/BRIEF.md
# Packed Float-to-Integer Lane Converter

This block turns packed single-precision floating-point lanes into 32-bit integers. Each lane is rounded and saturated on its own. The rounding direction and the signedness come from fields of a decoded vector instruction. Alongside the datapath, the same fields are checked for legality. An illegal encoding produces an all-zero result with the undefined-instruction flag raised.

Operands enter on a valid/ready stream, and results leave on a second valid/ready stream. The block holds one result register. A new operand is accepted when that register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the result and the flag hold still and no input is taken. An accepted operand appears at the output on the next clock edge, and the undefined flag travels with it.

Lane i occupies bits [32i+31:32i] of both the source and the result vector.

Top module: `fcvt_vec`

## Requirements
- R1: `rnd_sel` picks the rounding for every lane: 2'b00 nearest with ties away from zero, 2'b01 nearest with ties to even, 2'b10 toward plus infinity, 2'b11 toward minus infinity.
- R2: With `as_unsigned` = 1 each lane yields an unsigned 32-bit integer. With 0 it yields a two's-complement signed integer.
- R3: Only `elem_size` = 2'd2 (32-bit lanes, width 8 << size) is legal. Any other code raises `undef` and the result is all zeros.
- R4: With `wide` = 1, an odd `dst_idx` or an odd `src_idx` raises `undef` and the result is all zeros. With `wide` = 0, odd indices are legal.
- R5: `wide` = 1 converts four lanes. With `wide` = 0, lanes 0 and 1 are converted and result bits [127:64] are zero.
- R6: Out-of-range values saturate. Signed results clamp to 32'h7FFFFFFF and 32'h80000000. Unsigned results clamp to 32'hFFFFFFFF, and any negative result becomes 0.
- R7: A NaN lane (exponent all ones, nonzero fraction) yields 0. An infinity saturates to the bound on its own side.
- R8: Denormals and magnitudes below one round to 0 or to plus or minus 1 according to the mode. Examples: 0.5 becomes 1 under ties-away and 0 under ties-even, and a tiny positive denormal becomes 1 toward plus infinity.
- R9: An operand accepted at a clock edge presents its result and `undef` with `out_valid` high immediately after that edge.
- R10: While `out_valid` is high and `out_ready` is low, `res_vec`, `undef` and `out_valid` hold and `in_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R11: After reset, `out_valid` is low, `undef` is low and `res_vec` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and instruction fields present |
| in_ready | output | 1 | Operand accepted when high with in_valid |
| src_vec | input | 128 | Packed single-precision source lanes |
| wide | input | 1 | 1: four lanes, 0: two lanes |
| rnd_sel | input | 2 | Rounding mode select |
| as_unsigned | input | 1 | 1: unsigned result, 0: signed |
| elem_size | input | 2 | Element size code |
| dst_idx | input | 5 | Destination register index (legality only) |
| src_idx | input | 5 | Source register index (legality only) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result when high |
| res_vec | output | 128 | Packed integer result lanes |
| undef | output | 1 | Encoding was illegal; result is zero |

## Verification
Draining a finished result and accepting the next operand can happen in the same cycle. This occurs when `out_valid` and `out_ready` are both high while `in_valid` is asserted. The bench provokes it by issuing two operands on consecutive cycles, the second with an illegal encoding. It then checks that the first result was visible for exactly one cycle and that the next cycle already carries the second operand's zero result with `undef` set. It also releases a stalled output in the same cycle that a new operand arrives, and checks that the held value did not change during the stall.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int unsigned FLT_W    = 32;
  localparam int unsigned EXP_W    = 8;
  localparam int unsigned FRAC_W   = 23;
  localparam int unsigned MANT_W   = FRAC_W + 1;
  localparam int unsigned INT_W    = 32;
  localparam int unsigned EXP_BIAS = 127;
  localparam int unsigned SHIFT_CAP = INT_W + 1;
  localparam int unsigned EXT_W    = MANT_W + SHIFT_CAP + 8;
  localparam int unsigned WHOLE_W  = EXT_W - FRAC_W;
  localparam int unsigned MAG_W    = WHOLE_W + 1;

  typedef enum logic [1:0] {
    RND_AWAY = 2'b00,
    RND_EVEN = 2'b01,
    RND_UP   = 2'b10,
    RND_DOWN = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [FRAC_W-1:0] fr;
  } flt_t;
endpackage

// File: rtl/fcvt_legal.sv
module fcvt_legal #(
  parameter int unsigned IDX_W     = 5,
  parameter logic [1:0]  SIZE_OK   = 2'd2
) (
  input  logic             wide,
  input  logic [1:0]       elem_size,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src_idx,
  output logic             illegal
);
  localparam logic [IDX_W-1:0] ODD_MASK = IDX_W'(1);

  logic dst_odd, src_odd, size_bad;

  always_comb begin
    dst_odd  = (dst_idx & ODD_MASK) != '0;
    src_odd  = (src_idx & ODD_MASK) != '0;
    size_bad = (elem_size != SIZE_OK);
    illegal  = size_bad || (wide && (dst_odd || src_odd));
  end
endmodule

// File: rtl/fcvt_lane.sv
module fcvt_lane
  import fcvt_pkg::*;
(
  input  logic [FLT_W-1:0] src,
  input  rnd_mode_e        mode,
  input  logic             as_unsigned,
  output logic [INT_W-1:0] res
);
  localparam logic [EXP_W-1:0] EX_HALF = EXP_W'(EXP_BIAS - 1);
  localparam logic [EXP_W-1:0] EX_ONE  = EXP_W'(EXP_BIAS);
  localparam logic [EXP_W-1:0] EX_CAP  = EXP_W'(EXP_BIAS + SHIFT_CAP);
  localparam logic [EXP_W-1:0] EX_MAX  = '1;
  localparam int unsigned SH_W = $clog2(SHIFT_CAP + 1);
  localparam logic [MAG_W-1:0] S_POS_LIM = MAG_W'(64'h7FFF_FFFF);
  localparam logic [MAG_W-1:0] S_NEG_LIM = MAG_W'(64'h8000_0000);
  localparam logic [MAG_W-1:0] U_LIM     = MAG_W'(64'hFFFF_FFFF);
  localparam logic [INT_W-1:0] S_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] S_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] U_MAX = '1;

  flt_t f;
  logic is_nan, is_inf;
  logic [MANT_W-1:0]  mant;
  logic [SH_W-1:0]    sh;
  logic [EXT_W-1:0]   ext;
  logic [WHOLE_W-1:0] whole;
  logic guard, sticky, inc, inexact;
  logic [MAG_W-1:0]   mag;

  assign f = flt_t'(src);

  // split into whole part, guard bit and sticky bit
  always_comb begin
    is_nan = (f.ex == EX_MAX) && (f.fr != '0);
    is_inf = (f.ex == EX_MAX) && (f.fr == '0);
    mant   = {f.ex != '0, f.fr};
    sh     = '0;
    ext    = '0;
    whole  = '0;
    guard  = 1'b0;
    sticky = 1'b0;
    if (f.ex < EX_HALF) begin
      sticky = (f.ex != '0) || (f.fr != '0);
    end else if (f.ex == EX_HALF) begin
      guard  = 1'b1;
      sticky = (f.fr != '0);
    end else begin
      if (f.ex > EX_CAP) sh = SH_W'(SHIFT_CAP);
      else               sh = SH_W'(f.ex - EX_ONE);
      ext    = {{(EXT_W-MANT_W){1'b0}}, mant} << sh;
      whole  = ext[EXT_W-1:FRAC_W];
      guard  = ext[FRAC_W-1];
      sticky = |ext[FRAC_W-2:0];
    end
  end

  // rounding increment on the magnitude
  always_comb begin
    inexact = guard || sticky;
    unique case (mode)
      RND_AWAY: inc = guard;
      RND_EVEN: inc = guard && (sticky || whole[0]);
      RND_UP:   inc = !f.sgn && inexact;
      RND_DOWN: inc = f.sgn && inexact;
      default:  inc = 1'b0;
    endcase
    mag = {1'b0, whole} + MAG_W'(inc);
  end

  // saturate into the destination range
  always_comb begin
    if (is_nan) begin
      res = '0;
    end else if (as_unsigned) begin
      if (f.sgn)                       res = '0;
      else if (is_inf || mag > U_LIM)  res = U_MAX;
      else                             res = mag[INT_W-1:0];
    end else begin
      if (f.sgn) begin
        if (is_inf || mag > S_NEG_LIM) res = S_MIN;
        else                           res = INT_W'(-mag[INT_W-1:0]);
      end else begin
        if (is_inf || mag > S_POS_LIM) res = S_MAX;
        else                           res = mag[INT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/fcvt_outreg.sv
module fcvt_outreg #(
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_flag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_flag
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flag  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_flag  <= in_flag;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fcvt_vec.sv
module fcvt_vec
  import fcvt_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*FLT_W-1:0] src_vec,
  input  logic                   wide,
  input  logic [1:0]             rnd_sel,
  input  logic                   as_unsigned,
  input  logic [1:0]             elem_size,
  input  logic [IDX_W-1:0]       dst_idx,
  input  logic [IDX_W-1:0]       src_idx,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*INT_W-1:0] res_vec,
  output logic                   undef
);
  localparam int unsigned VEC_W      = LANES * INT_W;
  localparam int unsigned NARROW_LNS = LANES / 2;

  rnd_mode_e        mode;
  logic             illegal;
  logic [VEC_W-1:0] conv;
  logic [VEC_W-1:0] next_res;

  assign mode = rnd_mode_e'(rnd_sel);

  fcvt_legal #(.IDX_W(IDX_W)) legal_i (
    .wide      (wide),
    .elem_size (elem_size),
    .dst_idx   (dst_idx),
    .src_idx   (src_idx),
    .illegal   (illegal)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [INT_W-1:0] lane_res;
    fcvt_lane lane_i (
      .src         (src_vec[g*FLT_W +: FLT_W]),
      .mode        (mode),
      .as_unsigned (as_unsigned),
      .res         (lane_res)
    );
    if (g < NARROW_LNS) begin : g_low
      assign conv[g*INT_W +: INT_W] = lane_res;
    end else begin : g_high
      assign conv[g*INT_W +: INT_W] = wide ? lane_res : '0;
    end
  end

  assign next_res = illegal ? '0 : conv;

  fcvt_outreg #(.DATA_W(VEC_W)) oreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (next_res),
    .in_flag   (illegal),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_vec),
    .out_flag  (undef)
  );
endmodule

// File: rtl/fcvt_vec_chk.sv
module fcvt_vec_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         wide,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] res_vec,
  input logic         undef
);
  // R9
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_vec) && $stable(undef)));

  // R10
  stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R3
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && undef) |-> (res_vec == '0));

  // R5
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !wide) |=> (res_vec[127:64] == '0));

  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !(in_valid && in_ready)) |=> !out_valid);
endmodule

bind fcvt_vec fcvt_vec_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .wide      (wide),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .res_vec   (res_vec),
  .undef     (undef)
);

// File: tb/fcvt_vec_tb.sv
module fcvt_vec_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] src_vec = '0;
  logic         wide = 1'b1;
  logic [1:0]   rnd_sel = 2'b00;
  logic         as_unsigned = 1'b0;
  logic [1:0]   elem_size = 2'd2;
  logic [4:0]   dst_idx = '0;
  logic [4:0]   src_idx = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] res_vec;
  logic         undef;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fcvt_vec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_vec(src_vec), .wide(wide), .rnd_sel(rnd_sel), .as_unsigned(as_unsigned),
    .elem_size(elem_size), .dst_idx(dst_idx), .src_idx(src_idx),
    .out_valid(out_valid), .out_ready(out_ready), .res_vec(res_vec), .undef(undef)
  );

  // entry: {float bits, mode, unsigned, expected, tag 0..3}
  // tag 0: R1 rounding, 1: R6 saturation, 2: R7 specials, 3: R8 small values
  localparam int NV = 40;
  localparam logic [68:0] VEC [NV] = '{
    {32'h3FC00000, 2'b00, 1'b0, 32'h00000002, 2'd0},
    {32'h40200000, 2'b00, 1'b0, 32'h00000003, 2'd0},
    {32'h40200000, 2'b01, 1'b0, 32'h00000002, 2'd0},
    {32'h3FC00000, 2'b01, 1'b0, 32'h00000002, 2'd0},
    {32'hC0200000, 2'b00, 1'b0, 32'hFFFFFFFD, 2'd0},
    {32'hC0200000, 2'b01, 1'b0, 32'hFFFFFFFE, 2'd0},
    {32'h3FA00000, 2'b10, 1'b0, 32'h00000002, 2'd0},
    {32'h3FA00000, 2'b11, 1'b0, 32'h00000001, 2'd0},
    {32'hBFA00000, 2'b10, 1'b0, 32'hFFFFFFFF, 2'd0},
    {32'hBFA00000, 2'b11, 1'b0, 32'hFFFFFFFE, 2'd0},
    {32'h406CCCCD, 2'b11, 1'b0, 32'h00000003, 2'd0},
    {32'hC06CCCCD, 2'b10, 1'b0, 32'hFFFFFFFD, 2'd0},
    {32'h406CCCCD, 2'b00, 1'b1, 32'h00000004, 2'd0},
    {32'h42C80000, 2'b01, 1'b1, 32'h00000064, 2'd0},
    {32'h3F000000, 2'b01, 1'b0, 32'h00000000, 2'd3},
    {32'h3F000000, 2'b00, 1'b0, 32'h00000001, 2'd3},
    {32'h3E99999A, 2'b10, 1'b0, 32'h00000001, 2'd3},
    {32'h3E99999A, 2'b11, 1'b0, 32'h00000000, 2'd3},
    {32'hBE99999A, 2'b11, 1'b0, 32'hFFFFFFFF, 2'd3},
    {32'hBE99999A, 2'b10, 1'b0, 32'h00000000, 2'd3},
    {32'hBE99999A, 2'b00, 1'b0, 32'h00000000, 2'd3},
    {32'h00000001, 2'b10, 1'b0, 32'h00000001, 2'd3},
    {32'h00000001, 2'b01, 1'b0, 32'h00000000, 2'd3},
    {32'h80000001, 2'b11, 1'b0, 32'hFFFFFFFF, 2'd3},
    {32'h4F000000, 2'b01, 1'b0, 32'h7FFFFFFF, 2'd1},
    {32'hCF000000, 2'b01, 1'b0, 32'h80000000, 2'd1},
    {32'hCF000001, 2'b01, 1'b0, 32'h80000000, 2'd1},
    {32'h4EFFFFFF, 2'b01, 1'b0, 32'h7FFFFF80, 2'd1},
    {32'h4F000000, 2'b01, 1'b1, 32'h80000000, 2'd1},
    {32'h4F7FFFFF, 2'b01, 1'b1, 32'hFFFFFF00, 2'd1},
    {32'h4F800000, 2'b01, 1'b1, 32'hFFFFFFFF, 2'd1},
    {32'hBFA00000, 2'b11, 1'b1, 32'h00000000, 2'd1},
    {32'hBE99999A, 2'b11, 1'b1, 32'h00000000, 2'd1},
    {32'h7F800000, 2'b01, 1'b0, 32'h7FFFFFFF, 2'd2},
    {32'hFF800000, 2'b01, 1'b0, 32'h80000000, 2'd2},
    {32'h7F800000, 2'b10, 1'b1, 32'hFFFFFFFF, 2'd2},
    {32'hFF800000, 2'b11, 1'b1, 32'h00000000, 2'd2},
    {32'h7FC00000, 2'b00, 1'b0, 32'h00000000, 2'd2},
    {32'h7FC00000, 2'b10, 1'b1, 32'h00000000, 2'd2},
    {32'hFFC00001, 2'b11, 1'b0, 32'h00000000, 2'd2}
  };

  function automatic string tag_name(input logic [1:0] t, input logic u);
    case (t)
      2'd0:    return u ? "R1 R2 rounding" : "R1 rounding";
      2'd1:    return u ? "R6 R2 saturation" : "R6 saturation";
      2'd2:    return "R7 special";
      default: return "R8 small";
    endcase
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one operand at a negedge; sample at the next negedge
  task automatic issue(input logic [127:0] v, input logic [1:0] m, input logic u,
                       input logic w, input logic [1:0] sz,
                       input logic [4:0] di, input logic [4:0] si);
    @(negedge clk);
    src_vec = v; rnd_sel = m; as_unsigned = u; wide = w;
    elem_size = sz; dst_idx = di; src_idx = si; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 out_valid after reset", {127'b0, out_valid}, 128'd0);
    check("R11 undef after reset", {127'b0, undef}, 128'd0);
    check("R11 res_vec after reset", res_vec, 128'd0);
    rst_n = 1'b1;

    // table walk, same value in every lane
    for (int i = 0; i < NV; i++) begin
      logic [31:0] fb, ex;
      fb = VEC[i][68:37];
      ex = VEC[i][33:2];
      issue({4{fb}}, VEC[i][36:35], VEC[i][34], 1'b1, 2'd2, 5'd2, 5'd4);
      check($sformatf("%s #%0d", tag_name(VEC[i][1:0], VEC[i][34]), i), res_vec, {4{ex}});
      // R9 result present right after the accepting edge
      check("R9 valid with result", {126'b0, out_valid, undef}, 128'd2);
    end

    // R5 distinct lanes keep their order
    issue({32'h40200000, 32'hC0200000, 32'h3FC00000, 32'h42C80000}, 2'b00, 1'b0, 1'b1, 2'd2, 5'd0, 5'd0);
    check("R5 lane order wide", res_vec, {32'h3, 32'hFFFFFFFD, 32'h2, 32'h64});
    // R5 narrow, odd indices legal (R4)
    issue({32'h40200000, 32'hC0200000, 32'h3FC00000, 32'h42C80000}, 2'b00, 1'b0, 1'b0, 2'd2, 5'd3, 5'd7);
    check("R5 narrow upper zero", res_vec, {64'h0, 32'h2, 32'h64});
    check("R4 narrow odd legal", {127'b0, undef}, 128'd0);

    // R3 bad size codes
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      issue({4{32'h42C80000}}, 2'b00, 1'b0, 1'b1, 2'(s), 5'd0, 5'd0);
      check($sformatf("R3 size %0d undef", s), {127'b0, undef}, 128'd1);
      check($sformatf("R3 size %0d zero", s), res_vec, 128'd0);
    end
    // R4 odd destination, odd source in wide mode
    issue({4{32'h42C80000}}, 2'b00, 1'b0, 1'b1, 2'd2, 5'd1, 5'd0);
    check("R4 odd dst undef", {127'b0, undef}, 128'd1);
    check("R4 odd dst zero", res_vec, 128'd0);
    issue({4{32'h42C80000}}, 2'b00, 1'b0, 1'b1, 2'd2, 5'd0, 5'd9);
    check("R4 odd src undef", {127'b0, undef}, 128'd1);

    // R10 stall: result held, input refused
    @(negedge clk);
    out_ready = 1'b0;
    src_vec = {4{32'h3FC00000}}; rnd_sel = 2'b00; as_unsigned = 1'b0;
    wide = 1'b1; elem_size = 2'd2; dst_idx = '0; src_idx = '0; in_valid = 1'b1;
    @(negedge clk);
    src_vec = {4{32'h40200000}};
    check("R10 stalled in_ready low", {127'b0, in_ready}, 128'd0);
    repeat (2) @(negedge clk);
    check("R10 held result", res_vec, {4{32'h2}});
    check("R10 held valid", {126'b0, out_valid, undef}, 128'd2);
    // release while a new operand waits: drain and accept in one edge
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 R9 next after release", res_vec, {4{32'h3}});
    check("R10 R9 valid after release", {127'b0, out_valid}, 128'd1);

    // R9 back-to-back: legal then illegal on consecutive cycles
    @(negedge clk);
    src_vec = {4{32'h42C80000}}; rnd_sel = 2'b01; elem_size = 2'd2; in_valid = 1'b1;
    @(negedge clk);
    elem_size = 2'd3;
    check("R9 first of pair", res_vec, {4{32'h64}});
    check("R9 first flag", {127'b0, undef}, 128'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second of pair undef", {127'b0, undef}, 128'd1);
    check("R9 second of pair zero", res_vec, 128'd0);
    @(negedge clk);
    check("R9 idle drops valid", {127'b0, out_valid}, 128'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule